// File: doc/BRIEF.md
# Interrupt Enable Set/Clear Controller

This block gates the interrupt request of a host controller. It keeps an enable mask that software can change only through two aliases. One alias sets the bits written as 1, and the other clears the bits written as 1. A read through either alias returns the same mask. Beside the mask sits an event status register. Single-cycle event pulses set its bits, and software clears them by writing 1.

A single request line rises when the master enable (mask bit 31) is on and some status bit is pending whose enable bit is also on. Software reaches the block through a command/data port. A command code selects the register, and bit 7 of the code marks a write. Reads are combinational: read data is valid in the same cycle as the read strobe.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, the enable mask and the status register are all zeros, and `irq_o` is low.
- R2: A write with code 0x84 sets each implemented enable bit whose data bit is 1. Data bits of 0 leave the enable bits unchanged.
- R3: A write with code 0x85 clears each enable bit whose data bit is 1. Data bits of 0 leave the enable bits unchanged.
- R4: A read with code 0x04 and a read with code 0x05 both return the current enable mask. While `rd_stb` is low, `rd_data` is 0.
- R5: Sources sit at bit 0 (scheduling overrun), bit 2 (start of frame), bit 3 (resume detect), bit 4 (unrecoverable error), bit 5 (frame number overflow) and bit 6 (root hub status change). Bit 31 is the master enable. Bits 1 and 7 to 30 ignore writes and read as 0, so a full-ones set gives 0x8000007D.
- R6: An event pulse on a source bit sets that status bit on the next clock edge. A read with code 0x03 returns the status. Event pulses on non-source bits are ignored.
- R7: A write with code 0x83 clears each status bit whose data bit is 1, and leaves the other status bits unchanged.
- R8: `irq_o` is high exactly when the master enable is 1 and at least one status bit is set whose enable bit is also set.
- R9: Bit 31 is set only through code 0x84 and cleared only through code 0x85. While it is 0, `irq_o` stays low whatever the status.
- R10: When an event pulse and a status clear hit the same bit in the same cycle, the bit ends up set.
- R11: A write with any other code changes no register. A read with any other code returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_code | input | 8 | Command code; bit 7 marks a write |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| rd_stb | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid while `rd_stb` is high |
| event_i | input | 32 | Event pulses, one per status bit position |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can land on the same status bit in the same clock: the hardware event that sets the bit and the software write-1-to-clear that removes it. The bench drives both in one cycle on bit 3, with bit 0 already pending and also named in the clear data. It then reads the status back. Bit 3 must still be set, since the event wins, and bit 0 must be gone, which shows that the rest of the clear took effect. It also checks that `irq_o` follows the surviving bit.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
   localparam int unsigned CMD_W = 8;
   localparam logic [CMD_W-1:0] CODE_STATUS = 8'h03;
   localparam logic [CMD_W-1:0] CODE_ENSET  = 8'h04;
   localparam logic [CMD_W-1:0] CODE_ENCLR  = 8'h05;
   localparam int unsigned WR_FLAG_BIT = 7;

   typedef enum logic [1:0] {
      TGT_NONE   = 2'd0,
      TGT_STATUS = 2'd1,
      TGT_ENSET  = 2'd2,
      TGT_ENCLR  = 2'd3
   } tgt_e;
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
   import irq_mask_pkg::*;
(
   input  logic [CMD_W-1:0] cmd_code,
   input  logic             wr_stb,
   input  logic             rd_stb,
   output tgt_e             wr_tgt,
   output tgt_e             rd_tgt
);
   logic [CMD_W-1:0] base;
   logic             is_wr;
   tgt_e             hit;

   always_comb begin
      base = cmd_code;
      base[WR_FLAG_BIT] = 1'b0;
      is_wr = cmd_code[WR_FLAG_BIT];
      if (base == CODE_STATUS)      hit = TGT_STATUS;
      else if (base == CODE_ENSET)  hit = TGT_ENSET;
      else if (base == CODE_ENCLR)  hit = TGT_ENCLR;
      else                          hit = TGT_NONE;
      wr_tgt = (wr_stb && is_wr)  ? hit : TGT_NONE;
      rd_tgt = (rd_stb && !is_wr) ? hit : TGT_NONE;
   end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
   parameter int unsigned          DATA_W    = 32,
   parameter logic [DATA_W-1:0]    IMPL_MASK = 32'h8000_007D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] en_q
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_flop
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  q <= 1'b0;
            else if (set_we && wdata[i]) q <= 1'b1;
            else if (clr_we && wdata[i]) q <= 1'b0;
         end
         assign en_q[i] = q;
      end else begin : g_tie
         assign en_q[i] = 1'b0;
      end
   end

   // R2: written ones are set after a set-alias write
   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((en_q & $past(wdata & IMPL_MASK)) == $past(wdata & IMPL_MASK)));
   // R3: written ones are clear after a clear-alias write
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((en_q & $past(wdata)) == '0));
   // R11: without a write the mask holds
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(en_q));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int unsigned          DATA_W   = 32,
   parameter logic [DATA_W-1:0]    SRC_MASK = 32'h0000_007D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] event_i,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] st_q
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (SRC_MASK[i]) begin : g_flop
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  q <= 1'b0;
            else if (event_i[i])         q <= 1'b1;
            else if (clr_we && wdata[i]) q <= 1'b0;
         end
         assign st_q[i] = q;
      end else begin : g_tie
         assign st_q[i] = 1'b0;
      end
   end

   // R6: an event on a source bit sets it
   p_event_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((event_i & SRC_MASK) != '0) |=>
         ((st_q & $past(event_i & SRC_MASK)) == $past(event_i & SRC_MASK)));
   // R10: event wins over a simultaneous clear
   p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && ((event_i & wdata & SRC_MASK) != '0)) |=>
         ((st_q & $past(event_i & wdata & SRC_MASK)) != '0));
   // R7: cleared bits without an event drop
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((st_q & $past(wdata & ~event_i)) == '0));
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
   import irq_mask_pkg::*;
#(
   parameter int unsigned          DATA_W     = 32,
   parameter int unsigned          MASTER_BIT = 31,
   parameter logic [DATA_W-1:0]    SRC_MASK   = 32'h0000_007D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        cmd_code,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] event_i,
   output logic              irq_o
);
   localparam logic [DATA_W-1:0] MASTER_MASK = DATA_W'(1) << MASTER_BIT;
   localparam logic [DATA_W-1:0] IMPL_MASK   = SRC_MASK | MASTER_MASK;

   if (MASTER_BIT >= DATA_W) begin : g_bad_master
      $error("MASTER_BIT outside data width");
   end
   if ((SRC_MASK & MASTER_MASK) != '0) begin : g_bad_overlap
      $error("MASTER_BIT must not be a source bit");
   end
   if (CMD_W != 8) begin : g_bad_cmd
      $error("command code must be 8 bits");
   end

   tgt_e              wr_tgt, rd_tgt;
   logic [DATA_W-1:0] en_q, st_q;

   irq_cmd_decode u_dec (
      .cmd_code (cmd_code),
      .wr_stb   (wr_stb),
      .rd_stb   (rd_stb),
      .wr_tgt   (wr_tgt),
      .rd_tgt   (rd_tgt)
   );

   irq_enable_reg #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_tgt == TGT_ENSET),
      .clr_we (wr_tgt == TGT_ENCLR),
      .wdata  (wr_data),
      .en_q   (en_q)
   );

   irq_status_reg #(.DATA_W(DATA_W), .SRC_MASK(SRC_MASK)) u_st (
      .clk     (clk),
      .rst_n   (rst_n),
      .event_i (event_i),
      .clr_we  (wr_tgt == TGT_STATUS),
      .wdata   (wr_data),
      .st_q    (st_q)
   );

   always_comb begin
      case (rd_tgt)
         TGT_STATUS:          rd_data = st_q;
         TGT_ENSET, TGT_ENCLR: rd_data = en_q;
         default:             rd_data = '0;
      endcase
   end

   assign irq_o = en_q[MASTER_BIT] && ((st_q & en_q & SRC_MASK) != '0);

   // R9: master off keeps the request low
   p_master_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[MASTER_BIT] |-> !irq_o);
   // R8: no pending status means no request
   p_no_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == '0) |-> !irq_o);
   // R4: idle read port returns zero
   p_idle_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |-> (rd_data == '0));
endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cmd_code = '0;
   logic        wr_stb = 1'b0;
   logic        rd_stb = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [31:0] event_i = '0;
   logic        irq_o;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   irq_mask_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .wr_stb(wr_stb),
      .rd_stb(rd_stb), .wr_data(wr_data), .rd_data(rd_data),
      .event_i(event_i), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] code, input logic [31:0] data);
      @(negedge clk);
      cmd_code = code; wr_data = data; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0; wr_data = '0; cmd_code = '0;
   endtask

   task automatic do_read(input logic [7:0] code, output logic [31:0] val);
      @(negedge clk);
      cmd_code = code; rd_stb = 1'b1;
      #1 val = rd_data;
      rd_stb = 1'b0; cmd_code = '0;
   endtask

   task automatic pulse(input logic [31:0] ev);
      @(negedge clk);
      event_i = ev;
      @(negedge clk);
      event_i = '0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_read(8'h04, v); check("R1 enable", v, 32'h0);
      do_read(8'h03, v); check("R1 status", v, 32'h0);
      check("R1 irq", {31'b0, irq_o}, 32'h0);
      #1 check("R4 idle rd_data", rd_data, 32'h0);
   endtask

   task automatic t_set();
      logic [31:0] v;
      do_write(8'h84, 32'hFFFF_FFFF);
      do_read(8'h04, v); check("R5 set all", v, 32'h8000_007D);
      do_write(8'h84, 32'h0);
      do_read(8'h04, v); check("R2 zeros hold", v, 32'h8000_007D);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      do_write(8'h85, 32'h0000_0014);
      do_read(8'h04, v); check("R3 clear", v, 32'h8000_0069);
      do_read(8'h05, v); check("R4 alias read", v, 32'h8000_0069);
      do_write(8'h84, 32'h0000_0010);
      do_read(8'h05, v); check("R2 set one", v, 32'h8000_0079);
   endtask

   task automatic t_events();
      logic [31:0] v;
      do_write(8'h85, 32'h0000_0004);          // mask bit 2 off
      pulse(32'h0000_0004);
      do_read(8'h03, v); check("R6 status set", v, 32'h0000_0004);
      check("R8 masked no irq", {31'b0, irq_o}, 32'h0);
      do_write(8'h84, 32'h0000_0004);
      #1 check("R8 irq on", {31'b0, irq_o}, 32'h1);
      do_write(8'h85, 32'h8000_0000);
      #1 check("R9 master off", {31'b0, irq_o}, 32'h0);
      do_write(8'h84, 32'h8000_0000);
      #1 check("R9 master on", {31'b0, irq_o}, 32'h1);
      pulse(32'hFFFF_FF82);
      do_read(8'h03, v); check("R6 reserved events", v, 32'h0000_0004);
      do_write(8'h83, 32'h0000_0004);
      do_read(8'h03, v); check("R7 status clear", v, 32'h0);
      check("R8 irq after clear", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_collision();
      logic [31:0] v;
      pulse(32'h0000_0001);
      @(negedge clk);
      cmd_code = 8'h83; wr_data = 32'h0000_0009; wr_stb = 1'b1;
      event_i = 32'h0000_0008;
      @(negedge clk);
      wr_stb = 1'b0; wr_data = '0; cmd_code = '0; event_i = '0;
      do_read(8'h03, v); check("R10 event wins", v, 32'h0000_0008);
      check("R10 irq follows", {31'b0, irq_o}, 32'h1);
   endtask

   task automatic t_unknown();
      logic [31:0] v;
      do_write(8'h90, 32'hFFFF_FFFF);
      do_write(8'h86, 32'hFFFF_FFFF);
      do_read(8'h04, v); check("R11 enable unchanged", v, 32'h8000_007D);
      do_read(8'h03, v); check("R11 status unchanged", v, 32'h0000_0008);
      do_read(8'h10, v); check("R11 unknown read", v, 32'h0);
      do_read(8'h84, v); check("R11 write code read", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_set();
      t_clear();
      t_events();
      t_collision();
      t_unknown();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule